// File: doc/BRIEF.md
# ATA Task-File Register Window

This block is the host-facing register window of an ATA/ATAPI-style storage device. The host addresses byte-wide task-file registers, a command/status register, an alternate-status/device-control register and a 16-bit PIO data port. The device core sits on the other side. It supplies status, error, sense and PIO read data, and it receives the stored task-file bytes, a command-issue strobe, an interrupt-clear pulse, device-control writes and the PIO write path.

Several addresses select different registers for reads and for writes. Task-file and command writes are dropped while the core reports busy (BSY, status bit 7) or data request (DRQ, status bit 3). The pending interrupt is a level owned by a two-state machine. Its states are `IRQ_IDLE` and `IRQ_PENDING`. Three transitions act on it: RAISE (a core set pulse moves it to `IRQ_PENDING`), ACK (a status read or an accepted command write, with no set pulse in the same cycle, returns it to `IRQ_IDLE`) and HOLD (any other cycle leaves the state unchanged).

Host address map: 0 data, 1 feature (write) / error (read), 2 sector count, 3 LBA byte 0 (write) / sense (read), 4 LBA byte 1, 5 LBA byte 2, 6 device, 7 command (write) / status (read), 8 device control (write) / alternate status (read). Addresses 9 to 15 are unmapped.

Top module: `ata_taskfile_if`

## Requirements
- R1: While reset is asserted and after it is released, all six task-file outputs are 0. `irq`, `host_rvalid`, `cmd_issue`, `irq_clr` and `devctl_wr` are 0.
- R2: A write to address 1, 2, 3, 4, 5 or 6 stores `host_wdata[7:0]` into feature, count, LBA0, LBA1, LBA2 or device, visible on the clock after the write. The write takes effect only when `core_status` bit 7 (BSY) and bit 3 (DRQ) are both 0; otherwise it is dropped.
- R3: A read is answered on the next clock with `host_rvalid` high for one cycle. `host_rdata` is zero-extended and holds until the next read. Address 1 returns `core_error` and address 3 returns `core_sense`. Addresses 2, 4, 5 and 6 return the stored count, LBA1, LBA2 and device bytes. Addresses 7 and 8 return `core_status`.
- R4: Reads from addresses 9 to 15 return 0. Writes to them change no output.
- R5: A read from address 7 clears `irq` on the next clock and pulses `irq_clr`. A read from address 8 leaves `irq` unchanged.
- R6: An accepted write to address 7 clears `irq` and pulses `irq_clr` and `cmd_issue` together on the next clock, with `cmd_code` equal to `host_wdata[7:0]`. While BSY or DRQ is set, the write issues nothing and leaves `irq` unchanged.
- R7: `core_irq_set` makes `irq` high on the next clock. If a clearing condition occurs in the same cycle, the set wins.
- R8: A write to address 8 pulses `devctl_wr` on the next clock with `devctl_data` equal to `host_wdata[7:0]`, whatever the BSY and DRQ bits say.
- R9: At address 0, `core_pio_rd` and `core_pio_wr` follow `host_rd` and `host_wr` in the same cycle, and `core_pio_wdata` equals `host_wdata`. A data read returns all 16 bits of `core_pio_rdata` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 4 | Register address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Registered read data |
| host_rvalid | output | 1 | Read data valid pulse |
| irq | output | 1 | Pending device interrupt level |
| core_status | input | 8 | Device status byte |
| core_error | input | 8 | Device error byte |
| core_sense | input | 8 | Byte returned at address 3 |
| core_irq_set | input | 1 | Interrupt raise pulse |
| core_pio_rdata | input | 16 | PIO read data |
| core_pio_rd | output | 1 | PIO read strobe |
| core_pio_wr | output | 1 | PIO write strobe |
| core_pio_wdata | output | 16 | PIO write data |
| tf_feature | output | 8 | Stored feature byte |
| tf_count | output | 8 | Stored sector count |
| tf_lba0 | output | 8 | Stored LBA byte 0 |
| tf_lba1 | output | 8 | Stored LBA byte 1 |
| tf_lba2 | output | 8 | Stored LBA byte 2 |
| tf_device | output | 8 | Stored device byte |
| cmd_issue | output | 1 | Command issue pulse |
| cmd_code | output | 8 | Last issued command byte |
| irq_clr | output | 1 | Interrupt clear pulse toward the core |
| devctl_wr | output | 1 | Device-control write pulse |
| devctl_data | output | 8 | Last device-control byte |

## Verification
The PIO strobes and write data are combinational, so they are checked one nanosecond after the inputs change, in the same cycle. Every other result appears one clock after the access or core pulse: task-file bytes, read data and valid, `irq`, `irq_clr`, `cmd_issue` and `devctl_wr`. The bench's reference model updates on each rising edge from the inputs held across that edge. The outputs are compared with the model on the following falling edge, before the next stimulus is driven. The BSY and DRQ gating, the set-over-clear collision and the alternate-status read are driven directly, and a long random phase follows them.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    localparam int unsigned ST_BSY = 7;
    localparam int unsigned ST_DRQ = 3;

    localparam int unsigned ADR_DATA  = 0;
    localparam int unsigned ADR_FEAT  = 1;
    localparam int unsigned ADR_COUNT = 2;
    localparam int unsigned ADR_LBA0  = 3;
    localparam int unsigned ADR_LBA1  = 4;
    localparam int unsigned ADR_LBA2  = 5;
    localparam int unsigned ADR_DEV   = 6;
    localparam int unsigned ADR_CMD   = 7;
    localparam int unsigned ADR_ALT   = 8;

    localparam int unsigned TF_FEAT  = 0;
    localparam int unsigned TF_COUNT = 1;
    localparam int unsigned TF_LBA0  = 2;
    localparam int unsigned TF_LBA1  = 3;
    localparam int unsigned TF_LBA2  = 4;
    localparam int unsigned TF_DEV   = 5;
    localparam int unsigned TF_NUM   = 6;

    typedef struct packed {
        logic data;
        logic feat;
        logic count;
        logic lba0;
        logic lba1;
        logic lba2;
        logic dev;
        logic cmd;
        logic alt;
        logic unmapped;
    } sel_t;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_PENDING
    } irq_state_e;

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
    import ata_tf_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel
);

    always_comb begin
        sel          = '0;
        sel.data     = (addr == ADDR_W'(ADR_DATA));
        sel.feat     = (addr == ADDR_W'(ADR_FEAT));
        sel.count    = (addr == ADDR_W'(ADR_COUNT));
        sel.lba0     = (addr == ADDR_W'(ADR_LBA0));
        sel.lba1     = (addr == ADDR_W'(ADR_LBA1));
        sel.lba2     = (addr == ADDR_W'(ADR_LBA2));
        sel.dev      = (addr == ADDR_W'(ADR_DEV));
        sel.cmd      = (addr == ADDR_W'(ADR_CMD));
        sel.alt      = (addr == ADDR_W'(ADR_ALT));
        sel.unmapped = !(sel.data | sel.feat | sel.count | sel.lba0 | sel.lba1 |
                         sel.lba2 | sel.dev | sel.cmd | sel.alt);
    end

endmodule

// File: rtl/ata_tf_regfile.sv
module ata_tf_regfile
    import ata_tf_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  sel_t                          sel,
    input  logic                          allowed,
    input  logic [REG_W-1:0]              wbyte,
    output logic [TF_NUM-1:0][REG_W-1:0]  regs
);

    logic [TF_NUM-1:0] hit;
    logic [TF_NUM-1:0] wen;

    always_comb begin
        hit           = '0;
        hit[TF_FEAT]  = sel.feat;
        hit[TF_COUNT] = sel.count;
        hit[TF_LBA0]  = sel.lba0;
        hit[TF_LBA1]  = sel.lba1;
        hit[TF_LBA2]  = sel.lba2;
        hit[TF_DEV]   = sel.dev;
        wen           = hit & {TF_NUM{wr & allowed}};
    end

    for (genvar g = 0; g < TF_NUM; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wen[g]) begin
                regs[g] <= wbyte;
            end
        end
    end

    // R2
    blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !allowed) |=> $stable(regs));

    // R2
    accepted_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && allowed && sel.count) |=> (regs[TF_COUNT] == $past(wbyte)));

endmodule

// File: rtl/ata_tf_irq.sv
module ata_tf_irq
    import ata_tf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic ack,
    output logic irq_o
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (raise) state_d = IRQ_PENDING;
            end
            IRQ_PENDING: begin
                if (!raise && ack) state_d = IRQ_IDLE;
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_PENDING);
    end

    // R7
    raise_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> irq_o);

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !raise) |=> !irq_o);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !raise) |=> (irq_o == $past(irq_o)));

endmodule

// File: rtl/ata_taskfile_if.sv
module ata_taskfile_if
    import ata_tf_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              irq,
    input  logic [REG_W-1:0]  core_status,
    input  logic [REG_W-1:0]  core_error,
    input  logic [REG_W-1:0]  core_sense,
    input  logic              core_irq_set,
    input  logic [DATA_W-1:0] core_pio_rdata,
    output logic              core_pio_rd,
    output logic              core_pio_wr,
    output logic [DATA_W-1:0] core_pio_wdata,
    output logic [REG_W-1:0]  tf_feature,
    output logic [REG_W-1:0]  tf_count,
    output logic [REG_W-1:0]  tf_lba0,
    output logic [REG_W-1:0]  tf_lba1,
    output logic [REG_W-1:0]  tf_lba2,
    output logic [REG_W-1:0]  tf_device,
    output logic              cmd_issue,
    output logic [REG_W-1:0]  cmd_code,
    output logic              irq_clr,
    output logic              devctl_wr,
    output logic [REG_W-1:0]  devctl_data
);

    sel_t                         sel;
    logic                         allowed;
    logic                         cmd_accept;
    logic                         irq_ack;
    logic [REG_W-1:0]             wbyte;
    logic [DATA_W-1:0]            rd_mux;
    logic [TF_NUM-1:0][REG_W-1:0] regs;

    ata_tf_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (host_addr),
        .sel  (sel)
    );

    always_comb begin
        allowed    = !core_status[ST_BSY] && !core_status[ST_DRQ];
        wbyte      = host_wdata[REG_W-1:0];
        cmd_accept = host_wr && sel.cmd && allowed;
        irq_ack    = (host_rd && sel.cmd) || cmd_accept;
    end

    ata_tf_regfile #(.REG_W(REG_W)) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (host_wr),
        .sel     (sel),
        .allowed (allowed),
        .wbyte   (wbyte),
        .regs    (regs)
    );

    ata_tf_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (core_irq_set),
        .ack   (irq_ack),
        .irq_o (irq)
    );

    always_comb begin
        tf_feature = regs[TF_FEAT];
        tf_count   = regs[TF_COUNT];
        tf_lba0    = regs[TF_LBA0];
        tf_lba1    = regs[TF_LBA1];
        tf_lba2    = regs[TF_LBA2];
        tf_device  = regs[TF_DEV];
    end

    always_comb begin
        core_pio_rd    = host_rd && sel.data;
        core_pio_wr    = host_wr && sel.data;
        core_pio_wdata = host_wdata;
    end

    always_comb begin
        rd_mux = '0;
        if (sel.data)                 rd_mux = core_pio_rdata;
        else if (sel.feat)            rd_mux = DATA_W'(core_error);
        else if (sel.lba0)            rd_mux = DATA_W'(core_sense);
        else if (sel.count)           rd_mux = DATA_W'(regs[TF_COUNT]);
        else if (sel.lba1)            rd_mux = DATA_W'(regs[TF_LBA1]);
        else if (sel.lba2)            rd_mux = DATA_W'(regs[TF_LBA2]);
        else if (sel.dev)             rd_mux = DATA_W'(regs[TF_DEV]);
        else if (sel.cmd || sel.alt)  rd_mux = DATA_W'(core_status);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= host_rd;
            if (host_rd) host_rdata <= rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_issue   <= 1'b0;
            cmd_code    <= '0;
            irq_clr     <= 1'b0;
            devctl_wr   <= 1'b0;
            devctl_data <= '0;
        end else begin
            cmd_issue <= cmd_accept;
            irq_clr   <= irq_ack;
            devctl_wr <= host_wr && sel.alt;
            if (cmd_accept)          cmd_code    <= wbyte;
            if (host_wr && sel.alt)  devctl_data <= wbyte;
        end
    end

    // R3
    rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(host_rd));

    // R4
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && sel.unmapped) |=> (host_rdata == '0));

    // R6
    issue_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue |-> irq_clr);

    // R8
    devctl_ungated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && sel.alt) |=> (devctl_wr && devctl_data == $past(wbyte)));

endmodule

// File: tb/ata_taskfile_if_tb.sv
`timescale 1ns/1ps
module ata_taskfile_if_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic        irq;
    logic [7:0]  core_status = '0;
    logic [7:0]  core_error = 8'h04;
    logic [7:0]  core_sense = 8'h3C;
    logic        core_irq_set = 1'b0;
    logic [15:0] core_pio_rdata = 16'hBEEF;
    logic        core_pio_rd, core_pio_wr;
    logic [15:0] core_pio_wdata;
    logic [7:0]  tf_feature, tf_count, tf_lba0, tf_lba1, tf_lba2, tf_device;
    logic        cmd_issue, irq_clr, devctl_wr;
    logic [7:0]  cmd_code, devctl_data;

    always #2.5 clk = ~clk;

    ata_taskfile_if u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .irq(irq), .core_status(core_status),
        .core_error(core_error), .core_sense(core_sense),
        .core_irq_set(core_irq_set), .core_pio_rdata(core_pio_rdata),
        .core_pio_rd(core_pio_rd), .core_pio_wr(core_pio_wr),
        .core_pio_wdata(core_pio_wdata), .tf_feature(tf_feature),
        .tf_count(tf_count), .tf_lba0(tf_lba0), .tf_lba1(tf_lba1),
        .tf_lba2(tf_lba2), .tf_device(tf_device), .cmd_issue(cmd_issue),
        .cmd_code(cmd_code), .irq_clr(irq_clr), .devctl_wr(devctl_wr),
        .devctl_data(devctl_data)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // behavioural reference model
    logic [7:0]  m_tf [6];
    logic        m_irq, m_rvalid, m_issue, m_clr, m_dcwr;
    logic [15:0] m_rdata;
    logic [7:0]  m_code, m_dcdata;
    logic        m_allow, m_ack;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) m_tf[i] = 8'h00;
            m_irq = 0; m_rvalid = 0; m_issue = 0; m_clr = 0; m_dcwr = 0;
            m_rdata = 0; m_code = 0; m_dcdata = 0;
        end else begin
            m_allow  = !core_status[7] && !core_status[3];
            m_rvalid = host_rd;
            if (host_rd) begin
                case (host_addr)
                    4'd0:       m_rdata = core_pio_rdata;
                    4'd1:       m_rdata = {8'h00, core_error};
                    4'd2:       m_rdata = {8'h00, m_tf[1]};
                    4'd3:       m_rdata = {8'h00, core_sense};
                    4'd4:       m_rdata = {8'h00, m_tf[3]};
                    4'd5:       m_rdata = {8'h00, m_tf[4]};
                    4'd6:       m_rdata = {8'h00, m_tf[5]};
                    4'd7, 4'd8: m_rdata = {8'h00, core_status};
                    default:    m_rdata = 16'h0000;
                endcase
            end
            m_issue = host_wr && host_addr == 4'd7 && m_allow;
            m_ack   = (host_rd && host_addr == 4'd7) || m_issue;
            m_clr   = m_ack;
            if (m_issue) m_code = host_wdata[7:0];
            m_dcwr = host_wr && host_addr == 4'd8;
            if (m_dcwr) m_dcdata = host_wdata[7:0];
            if (host_wr && m_allow && host_addr >= 4'd1 && host_addr <= 4'd6)
                m_tf[host_addr - 4'd1] = host_wdata[7:0];
            if (core_irq_set) m_irq = 1;
            else if (m_ack)   m_irq = 0;
        end
    end

    task automatic compare();
        chk("R2 feature", {8'h0, tf_feature}, {8'h0, m_tf[0]});
        chk("R2 count",   {8'h0, tf_count},   {8'h0, m_tf[1]});
        chk("R2 lba0",    {8'h0, tf_lba0},    {8'h0, m_tf[2]});
        chk("R2 lba1",    {8'h0, tf_lba1},    {8'h0, m_tf[3]});
        chk("R2 lba2",    {8'h0, tf_lba2},    {8'h0, m_tf[4]});
        chk("R2 device",  {8'h0, tf_device},  {8'h0, m_tf[5]});
        chk("R3 rvalid",  {15'h0, host_rvalid}, {15'h0, m_rvalid});
        chk("R3 rdata",   host_rdata, m_rdata);
        chk("R7 irq",     {15'h0, irq}, {15'h0, m_irq});
        chk("R5 irq_clr", {15'h0, irq_clr}, {15'h0, m_clr});
        chk("R6 cmd_issue", {15'h0, cmd_issue}, {15'h0, m_issue});
        chk("R6 cmd_code",  {8'h0, cmd_code}, {8'h0, m_code});
        chk("R8 devctl_wr", {15'h0, devctl_wr}, {15'h0, m_dcwr});
        chk("R8 devctl_data", {8'h0, devctl_data}, {8'h0, m_dcdata});
    endtask

    task automatic op(bit wr, bit rd, logic [3:0] a, logic [15:0] d, bit set, logic [7:0] st);
        @(negedge clk);
        compare();
        host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d;
        core_irq_set = set; core_status = st;
        #1;
        chk("R9 pio_rd", {15'h0, core_pio_rd}, {15'h0, rd && a == 4'd0});
        chk("R9 pio_wr", {15'h0, core_pio_wr}, {15'h0, wr && a == 4'd0});
        chk("R9 pio_wdata", core_pio_wdata, d);
    endtask

    task automatic idle(logic [7:0] st);
        op(0, 0, 4'd0, 16'h0, 0, st);
    endtask

    bit finished = 0;

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 irq", {15'h0, irq}, 16'h0);
        chk("R1 rvalid", {15'h0, host_rvalid}, 16'h0);
        chk("R1 cmd_issue", {15'h0, cmd_issue}, 16'h0);
        chk("R1 feature", {8'h0, tf_feature}, 16'h0);
        rst_n = 1'b1;
        idle(8'h00);
        // R2 writes, low byte only
        op(1, 0, 4'd1, 16'h1A5, 0, 8'h00);
        op(1, 0, 4'd2, 16'h0010, 0, 8'h50);
        op(1, 0, 4'd3, 16'hFF11, 0, 8'h00);
        op(1, 0, 4'd4, 16'h0022, 0, 8'h00);
        op(1, 0, 4'd5, 16'h0033, 0, 8'h00);
        op(1, 0, 4'd6, 16'h00E0, 0, 8'h00);
        idle(8'h00);
        chk("R2 feature low byte", {8'h0, tf_feature}, 16'h00A5);
        // R3 read mapping
        op(0, 1, 4'd1, 16'h0, 0, 8'h50);
        op(0, 1, 4'd3, 16'h0, 0, 8'h50);
        op(0, 1, 4'd2, 16'h0, 0, 8'h50);
        op(0, 1, 4'd4, 16'h0, 0, 8'h50);
        op(0, 1, 4'd6, 16'h0, 0, 8'h50);
        op(0, 1, 4'd8, 16'h0, 0, 8'h51);
        idle(8'h50);
        chk("R3 alt status", host_rdata, 16'h0051);
        // R4 unmapped
        op(1, 0, 4'd9, 16'h00FF, 0, 8'h00);
        op(1, 0, 4'd15, 16'h00FF, 0, 8'h00);
        op(0, 1, 4'd12, 16'h0, 0, 8'h00);
        idle(8'h00);
        chk("R4 unmapped read", host_rdata, 16'h0000);
        // R5 alt read keeps irq, status read clears
        op(0, 0, 4'd0, 16'h0, 1, 8'h00);
        op(0, 1, 4'd8, 16'h0, 0, 8'h00);
        idle(8'h00);
        chk("R5 alt keeps irq", {15'h0, irq}, 16'h1);
        op(0, 1, 4'd7, 16'h0, 0, 8'h00);
        idle(8'h00);
        chk("R5 status read clears irq", {15'h0, irq}, 16'h0);
        // R6 gating by BSY and DRQ
        op(0, 0, 4'd0, 16'h0, 1, 8'h00);
        op(1, 0, 4'd2, 16'h0077, 0, 8'h80);
        op(1, 0, 4'd7, 16'h00EC, 0, 8'h80);
        op(1, 0, 4'd5, 16'h0066, 0, 8'h08);
        op(1, 0, 4'd7, 16'h00A0, 0, 8'h08);
        idle(8'h08);
        chk("R6 blocked cmd keeps irq", {15'h0, irq}, 16'h1);
        chk("R2 blocked count", {8'h0, tf_count}, 16'h0010);
        op(1, 0, 4'd7, 16'h01EC, 0, 8'h50);
        idle(8'h50);
        chk("R6 cmd_code", {8'h0, cmd_code}, 16'h00EC);
        // R7 set wins over clear in same cycle
        op(1, 0, 4'd7, 16'h0025, 1, 8'h00);
        op(0, 1, 4'd7, 16'h0, 1, 8'h00);
        idle(8'h00);
        chk("R7 set wins", {15'h0, irq}, 16'h1);
        // R8 device control while busy
        op(1, 0, 4'd8, 16'h0306, 0, 8'h88);
        idle(8'h88);
        // R9 data port
        core_pio_rdata = 16'hC0DE;
        op(1, 0, 4'd0, 16'h1234, 0, 8'h58);
        op(0, 1, 4'd0, 16'h0, 0, 8'h58);
        idle(8'h00);
        chk("R9 pio read data", host_rdata, 16'hC0DE);
        // random phase
        for (int i = 0; i < 2000; i++) begin
            automatic int kind = $urandom_range(0, 2);
            automatic logic [7:0] sts [5] = '{8'h00, 8'h50, 8'h80, 8'h08, 8'h58};
            core_error     = 8'($urandom);
            core_sense     = 8'($urandom);
            core_pio_rdata = 16'($urandom);
            op(kind == 1, kind == 2, 4'($urandom), 16'($urandom),
               ($urandom_range(0, 7) == 0), sts[$urandom_range(0, 4)]);
        end
        idle(8'h00);
        idle(8'h00);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule